// File: doc/BRIEF.md
# Selectable Square Wave Generator with Shared Output Pin

This block derives a square wave from a 32.768 kHz timebase and places it on a single output pin that is shared with an interrupt line and a calibration signal. A two-bit rate code picks one of four output rates: 1 Hz, 512 Hz, 4096 Hz, or the timebase itself. The slower three come from a free-running binary divider that advances on every rising edge of the timebase, so every one of them has a 50 % duty cycle.

The pin is driven by a registered priority selector. An active calibration enable puts the calibration signal on the pin ahead of everything else. Below that, the square wave wins when it is enabled and the device is not on backup power. Otherwise, the interrupt input passes through. The timebase enters through a synchronizer in the system clock domain. Every control input is sampled in that domain, so a change of source or rate takes effect only at a clock edge.

Top module: `sqw_gen`

## Requirements
- R1: With wave enabled, no calibration and no backup power, rate code 2'b00 gives the 1 Hz wave. It equals bit TAP_SLOW (14 by default) of the count of timebase rising edges, so it has a period of 2^(TAP_SLOW+1) timebase periods and is high for exactly half of them.
- R2: Under the same conditions, rate code 2'b01 gives the 512 Hz wave: bit TAP_MID (5 by default) of the edge count.
- R3: Under the same conditions, rate code 2'b10 gives the 4096 Hz wave: bit TAP_FAST (2 by default) of the edge count.
- R4: Under the same conditions, rate code 2'b11 puts the synchronized timebase level itself on the pin.
- R5: While cal_en is 1, pin_out follows cal_sig, whatever the values of wave_en, on_backup, rate_sel and irq_in.
- R6: While on_backup is 1 and cal_en is 0, the square wave is suppressed and pin_out follows irq_in, even with wave_en at 1.
- R7: While wave_en is 0 and cal_en is 0, pin_out follows irq_in.
- R8: The edge counter advances by one on every timebase rising edge and wraps at 2^DIV_W. A change of rate code, enable or source neither restarts nor pauses it.
- R9: pin_out is a register. It reflects control and data inputs one clock later and the tbase_in level three clocks later. A synchronous reset with rst_n low clears pin_out and the edge counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tbase_in | input | 1 | 32.768 kHz timebase level, asynchronous to clk |
| rate_sel | input | 2 | Output rate code (00 1 Hz, 01 512 Hz, 10 4096 Hz, 11 timebase) |
| wave_en | input | 1 | Square wave enable |
| cal_en | input | 1 | Calibration output enable, highest priority |
| cal_sig | input | 1 | Calibration signal driven to the pin when cal_en is 1 |
| irq_in | input | 1 | Interrupt level, lowest priority |
| on_backup | input | 1 | High while the device runs on backup power |
| pin_out | output | 1 | Shared interrupt/square wave pin |

## Verification
The hardest case to reach from the ports is the slowest rate. Its toggle takes tens of thousands of timebase periods, and a rate change can arrive anywhere in the divider's phase. To reach it, the bench builds the block with a narrow divider and low taps. It then steps through every rate code and every combination of cal_en, on_backup and wave_en while the timebase keeps running, so each switch lands at a different counter phase. A pseudo-random sequence drives irq_in and cal_sig so that the fallback sources change too. One long run per rate covers full periods of the slowest tap, and a reset in mid-run checks that the counter and pin clear.

// File: rtl/sqw_pkg.sv
// Package: shared encodings of the square wave generator.
// Assumes: rate codes are fixed by the register field that feeds rate_sel.
package sqw_pkg;

    // Output rate code carried on rate_sel
    typedef enum logic [1:0] {
        RATE_SLOW = 2'b00,
        RATE_MID  = 2'b01,
        RATE_FAST = 2'b10,
        RATE_PASS = 2'b11
    } sqw_rate_e;

    // Source that currently owns the shared pin
    typedef enum logic [1:0] {
        SRC_IRQ  = 2'b00,
        SRC_WAVE = 2'b01,
        SRC_CAL  = 2'b10
    } pin_src_e;

endpackage

// File: rtl/sqw_tb_sync.sv
// Module: sqw_tb_sync
// Brings the asynchronous timebase level into the clk domain and flags its
// rising edges. Assumes: each timebase half period lasts at least two clk cycles.
// Outputs: tb_lvl, the level delayed by SYNC_STAGES+1 registers, and tb_rise,
// a one-cycle strobe aligned with tb_lvl.
module sqw_tb_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tb_async,
    output logic tb_lvl,
    output logic tb_rise
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] sr_q;

    // Shift the raw timebase through the synchronizer chain plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[DEPTH-2:0], tb_async};
    end

    // Rising edge: newest synchronized sample high, history stage still low
    always_comb begin
        tb_lvl  = sr_q[DEPTH-1];
        tb_rise = sr_q[DEPTH-2] & ~sr_q[DEPTH-1];
    end

    // A rising-edge strobe lasts one cycle only (R9 timing path)
    assert_rise_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tb_rise |=> !tb_rise);

endmodule

// File: rtl/sqw_divider.sv
// Module: sqw_divider
// Free-running binary counter of timebase rising edges; exposes three tap bits.
// Assumes: TAP_* are below DIV_W. The counter never restarts except on reset.
module sqw_divider #(
    parameter int DIV_W     = 15,
    parameter int TAP_SLOW  = 14,
    parameter int TAP_MID   = 5,
    parameter int TAP_FAST  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    output logic [2:0] taps
);
    logic [DIV_W-1:0] cnt_q;

    // Count one per timebase rising edge, wrapping at 2^DIV_W
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    // Present the chosen bits, slowest in bit 2
    always_comb begin
        taps = {cnt_q[TAP_SLOW], cnt_q[TAP_MID], cnt_q[TAP_FAST]};
    end

    assert_div_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> cnt_q == $past(cnt_q) + 1'b1);
    assert_div_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q));
    assert_div_reset_R9: assert property (@(posedge clk)
        !rst_n |=> cnt_q == '0);

endmodule

// File: rtl/sqw_rate_sel.sv
// Module: sqw_rate_sel
// Picks the square wave for the current rate code. Purely combinational.
// Assumes: taps[2] slow, taps[1] mid, taps[0] fast; level is the timebase.
module sqw_rate_sel
    import sqw_pkg::*;
(
    input  logic [2:0] taps,
    input  logic       level,
    input  logic [1:0] rate,
    output logic       wave
);
    // Map the rate code onto a divider tap or the timebase itself
    always_comb begin
        unique case (sqw_rate_e'(rate))
            RATE_SLOW: wave = taps[2];
            RATE_MID:  wave = taps[1];
            RATE_FAST: wave = taps[0];
            default:   wave = level;
        endcase
    end

endmodule

// File: rtl/sqw_pin_mux.sv
// Module: sqw_pin_mux
// Registered priority selector for the shared pin: calibration, then square
// wave (if enabled and not on backup power), then interrupt.
// Assumes: all inputs are in the clk domain. The register keeps the pin
// free of glitches when the source changes.
module sqw_pin_mux
    import sqw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cal_en,
    input  logic cal_sig,
    input  logic wave_en,
    input  logic on_backup,
    input  logic wave,
    input  logic irq_in,
    output logic pin_q
);
    pin_src_e src;
    logic     pin_d;

    // Decide which source owns the pin this cycle
    always_comb begin
        if (cal_en)                     src = SRC_CAL;
        else if (wave_en && !on_backup) src = SRC_WAVE;
        else                            src = SRC_IRQ;
    end

    // Route the chosen source
    always_comb begin
        unique case (src)
            SRC_CAL:  pin_d = cal_sig;
            SRC_WAVE: pin_d = wave;
            default:  pin_d = irq_in;
        endcase
    end

    // Register the pin so a source change lands on a clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assert_cal_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cal_en |=> pin_q == $past(cal_sig));
    assert_backup_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_en && on_backup) |=> pin_q == $past(irq_in));
    assert_disabled_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_en && !wave_en) |=> pin_q == $past(irq_in));
    assert_pin_reset_R9: assert property (@(posedge clk)
        !rst_n |=> pin_q == 1'b0);

endmodule

// File: rtl/sqw_gen.sv
// Module: sqw_gen (top)
// Square wave generator with a shared interrupt/calibration pin.
// Assumes: tbase_in is a 32.768 kHz level whose half period spans at least
// two clk cycles. The default taps give 1 Hz, 512 Hz and 4096 Hz.
module sqw_gen #(
    parameter int DIV_W       = 15,
    parameter int TAP_SLOW    = 14,
    parameter int TAP_MID     = 5,
    parameter int TAP_FAST    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tbase_in,
    input  logic [1:0] rate_sel,
    input  logic       wave_en,
    input  logic       cal_en,
    input  logic       cal_sig,
    input  logic       irq_in,
    input  logic       on_backup,
    output logic       pin_out
);
    logic       tb_lvl;
    logic       tb_rise;
    logic [2:0] taps;
    logic       wave;

    sqw_tb_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tb_async (tbase_in),
        .tb_lvl   (tb_lvl),
        .tb_rise  (tb_rise)
    );

    sqw_divider #(
        .DIV_W    (DIV_W),
        .TAP_SLOW (TAP_SLOW),
        .TAP_MID  (TAP_MID),
        .TAP_FAST (TAP_FAST)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (tb_rise),
        .taps  (taps)
    );

    sqw_rate_sel u_sel (
        .taps  (taps),
        .level (tb_lvl),
        .rate  (rate_sel),
        .wave  (wave)
    );

    sqw_pin_mux u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_en    (cal_en),
        .cal_sig   (cal_sig),
        .wave_en   (wave_en),
        .on_backup (on_backup),
        .wave      (wave),
        .irq_in    (irq_in),
        .pin_q     (pin_out)
    );

    // Timebase pass-through rate puts the synchronized level on the pin
    assert_pass_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_en && wave_en && !on_backup && rate_sel == 2'b11)
        |=> pin_out == $past(tb_lvl));

endmodule

// File: tb/test_sqw_gen.sv
// Bench for sqw_gen, built with a narrow divider so that slow taps complete
// full periods. A cycle-level arithmetic model predicts pin_out.
module test_sqw_gen;
    localparam int DIV_W  = 8;
    localparam int T_SLOW = 7;
    localparam int T_MID  = 4;
    localparam int T_FAST = 1;
    localparam int HALF   = 4;   // clk cycles per timebase half period

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tbase_in;
    logic [1:0] rate_sel;
    logic       wave_en, cal_en, cal_sig, irq_in, on_backup;
    logic       pin_out;

    int  vectors = 0;
    int  errors  = 0;
    bit  check_en = 1'b0;
    bit  done = 1'b0;

    // Model state
    logic             xs1, xs2, xs3;
    logic [DIV_W-1:0] cnt_m;
    logic             exp_pin;
    string            exp_req;
    logic             wv;

    always #2 clk = ~clk;

    sqw_gen #(
        .DIV_W    (DIV_W),
        .TAP_SLOW (T_SLOW),
        .TAP_MID  (T_MID),
        .TAP_FAST (T_FAST)
    ) i_sqw_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .tbase_in  (tbase_in),
        .rate_sel  (rate_sel),
        .wave_en   (wave_en),
        .cal_en    (cal_en),
        .cal_sig   (cal_sig),
        .irq_in    (irq_in),
        .on_backup (on_backup),
        .pin_out   (pin_out)
    );

    // Model: the pin holds the selected source one edge later; the timebase is
    // seen three edges late; the edge counter never restarts (R8).
    always @(posedge clk) begin
        if (!rst_n) begin
            xs1 = 1'b0; xs2 = 1'b0; xs3 = 1'b0;
            cnt_m = '0;
            exp_pin = 1'b0;
            exp_req = "R9";
        end else begin
            case (rate_sel)
                2'b00:   wv = cnt_m[T_SLOW];
                2'b01:   wv = cnt_m[T_MID];
                2'b10:   wv = cnt_m[T_FAST];
                default: wv = xs3;
            endcase
            if (cal_en) begin
                exp_pin = cal_sig; exp_req = "R5";
            end else if (on_backup) begin
                exp_pin = irq_in; exp_req = "R6";
            end else if (!wave_en) begin
                exp_pin = irq_in; exp_req = "R7";
            end else begin
                exp_pin = wv;
                case (rate_sel)
                    2'b00:   exp_req = "R1,R8";
                    2'b01:   exp_req = "R2,R8";
                    2'b10:   exp_req = "R3,R8";
                    default: exp_req = "R4";
                endcase
            end
            if (xs2 && !xs3) cnt_m = cnt_m + 1'b1;
            xs3 = xs2; xs2 = xs1; xs1 = tbase_in;
        end
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        if (check_en && !done) begin
            vectors++;
            if (pin_out !== exp_pin) begin
                errors++;
                $display("FAIL %s: pin_out=%b expected=%b at %0t", exp_req, pin_out, exp_pin, $time);
            end
        end
    end

    // Free-running timebase
    initial begin
        tbase_in = 1'b0;
        forever begin
            repeat (HALF) @(negedge clk);
            tbase_in = ~tbase_in;
        end
    end

    // Pseudo-random interrupt and calibration levels
    initial begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        irq_in = 1'b0; cal_sig = 1'b0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            irq_in  = lfsr[0];
            cal_sig = lfsr[3];
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        rate_sel = 2'b00; wave_en = 1'b1; cal_en = 1'b0; on_backup = 1'b0;
        repeat (5) @(negedge clk);
        // Reset state of the pin (R9)
        vectors++;
        if (pin_out !== 1'b0) begin
            errors++;
            $display("FAIL R9: reset pin_out=%b expected=0", pin_out);
        end
        check_en = 1'b1;
        rst_n = 1'b1;
        // Sweep every rate and every priority combination (R1..R7)
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 8; m++) begin
                rate_sel  = 2'(s);
                cal_en    = m[2];
                on_backup = m[1];
                wave_en   = m[0];
                repeat (300 + 7 * m) @(negedge clk);
            end
        end
        // Full periods of every tap with the wave owning the pin (R1..R4, R8)
        cal_en = 1'b0; on_backup = 1'b0; wave_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            rate_sel = 2'(s);
            repeat ((1 << (T_SLOW + 1)) * 2 * HALF + 37) @(negedge clk);
        end
        // Reset in mid-run clears counter and pin (R9)
        rate_sel = 2'b01;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2000) @(negedge clk);
        finish_run();
    end

endmodule